// File: doc/BRIEF.md
# LCD Panel Configuration Sequencer

This block powers a small LCD panel up and down and keeps its setup registers programmed. The panel is configured only by writes over a write-only SPI link. Each write is one 16-bit frame that carries a 6-bit register address, a write flag and one data byte. A host raises single-cycle requests to power the panel on, to power it off, or to refresh its mirror setting. The block then runs a fixed script. The script switches the panel supply, drives the active-low panel reset, waits the settling times and issues the register writes in order.

Runtime settings are held in the block and are reloaded from the configuration inputs with a load strobe while the block is idle. The settings are a 3-bit mode, a horizontal and a vertical mirror flag, and twelve 10-bit gamma points. Both settling waits are counted in clock cycles and derived from a clock-frequency parameter. While a script runs, the block holds busy high and ignores new requests. It pulses done when the script ends.

Top module: `lcd_cfg_seq`

## Requirements
- R1: Reset state. After reset: supply enable low, panel reset low, chip select high, SCLK low, busy low, done low. The held settings are mode 7, both mirror flags clear, and gamma points 105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023 (point 0 first).
- R2: Frame format. Each write is one SPI mode-0 frame: SCLK idles low and MOSI is stable at each rising SCLK edge.
  - Bits go out MSB first, with the address in bits 15:10, bit 9 at 0, bit 8 at 1 and the data in bits 7:0.
  - Chip select stays low across exactly 16 rising SCLK edges.
  - Chip select then stays high for at least one SCLK period before the next frame.
- R3: Power-up timing. A power-on request raises the supply enable in the next cycle. The panel reset then stays low, and no frame is sent, for ON_MS*CLK_KHZ cycles. The reset is released before the first frame.
- R4: Power-up script order. The power-up script sends 20 frames in this order:
  - register 0x02 with data = mode | 0x08;
  - register 0x03 with 0xDA;
  - register 0x20 with 0xF0;
  - register 0x21 with 0xF0;
  - register 0x04;
  - registers 0x11, 0x12, 0x13;
  - registers 0x14 to 0x1F.
- R5: Mirror byte. The register 0x04 data is 0x17 with bit 0 cleared when the horizontal mirror flag is set and bit 1 cleared when the vertical mirror flag is set. The four cases are 0x17, 0x16, 0x15 and 0x14.
- R6: Gamma high bits. Register 0x11+k (k = 0..2) carries bits 9:8 of gamma points 4k..4k+3. Point 4k goes in data bits 7:6, point 4k+1 in 5:4, point 4k+2 in 3:2 and point 4k+3 in 1:0.
- R7: Gamma low bits. Register 0x14+i (i = 0..11) carries bits 7:0 of gamma point i.
- R8: Power-down script. A power-off request first sends register 0x03 with 0xD8 while the reset is still high. It then drives the reset low and waits at least OFF_MS*CLK_KHZ cycles. Next it sends register 0x03 with 0xD0, and after that frame it drops the supply enable.
- R9: Ignored requests. These produce no frame, no busy and no done, and leave the supply and reset unchanged:
  - a power-on request while powered;
  - a power-off request while unpowered;
  - a mirror request while unpowered.
- R10: Mirror update. A mirror request while powered and idle sends exactly one frame, register 0x04, built from the held mirror flags.
- R11: Busy and done. Busy is high from the cycle after a request is accepted until the script ends. Done is a one-cycle pulse in the first cycle with busy low again. Requests and load strobes that arrive while busy are ignored.
- R12: Request priority. When power-off and mirror requests arrive together while powered, only the power-down script runs.
- R13: Settings load. A load strobe while idle latches the mode, mirror flags and gamma inputs. The next script uses the latched values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Power-up request pulse |
| pwr_off_req | input | 1 | Power-down request pulse |
| mirror_req | input | 1 | Mirror refresh request pulse |
| cfg_load | input | 1 | Latch the configuration inputs when idle |
| cfg_mode | input | 3 | Panel mode value |
| cfg_hmir | input | 1 | Horizontal mirror flag |
| cfg_vmir | input | 1 | Vertical mirror flag |
| cfg_gamma | input | 120 | Twelve 10-bit gamma points, point i at bits 10i+9:10i |
| vdd_en | output | 1 | Panel supply enable |
| panel_rst_n | output | 1 | Active-low panel reset |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to panel |
| spi_cs_n | output | 1 | SPI chip select, active low |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle script completion pulse |

## Verification
The bench builds the block with CLK_KHZ = 1, ON_MS = 160, OFF_MS = 50 and SCLK_HALF = 1. With these values the settle waits are 160 and 50 cycles, and every SCLK phase lasts one clock. Whole power-up and power-down scripts therefore complete within a few thousand cycles. The bench can then check the wait bounds exactly and check every frame of several scripts bit by bit, with default and loaded settings.

// File: rtl/lcd_cfg_pkg.sv
package lcd_cfg_pkg;

  localparam int GPTS   = 12;
  localparam int GBITS  = 10;
  localparam int FRAMEW = 16;
  localparam int ON_STEPS = 20;

  typedef logic [GPTS-1:0][GBITS-1:0] gamma_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ON_WAIT, S_ON_WR, S_MIR_WR, S_OFF_W1, S_OFF_WAIT, S_OFF_W2
  } seq_state_e;

  typedef enum logic [1:0] {FK_ON, FK_MIR, FK_OFF1, FK_OFF2} frame_kind_e;

  localparam logic [5:0] A_MODE  = 6'h02;
  localparam logic [5:0] A_PWR   = 6'h03;
  localparam logic [5:0] A_FLIP  = 6'h04;
  localparam logic [5:0] A_GHI   = 6'h11;
  localparam logic [5:0] A_GLO   = 6'h14;
  localparam logic [5:0] A_DRV0  = 6'h20;
  localparam logic [5:0] A_DRV1  = 6'h21;

  localparam logic [7:0] PWR_RUN  = 8'hDA;
  localparam logic [7:0] PWR_PWM  = 8'hD8;
  localparam logic [7:0] PWR_STBY = 8'hD0;
  localparam logic [7:0] DRV_VAL  = 8'hF0;
  localparam logic [7:0] FLIP_BASE = 8'h17;
  localparam logic [2:0] DEF_MODE = 3'd7;

  // Address in 15:10, fixed zero at 9, write flag at 8, data in 7:0.
  function automatic logic [FRAMEW-1:0] mk_frame(input logic [5:0] a, input logic [7:0] d);
    return {a, 1'b0, 1'b1, d};
  endfunction

  function automatic logic [7:0] flip_byte(input logic h, input logic v);
    logic [7:0] b;
    b = FLIP_BASE;
    if (h) b[0] = 1'b0;
    if (v) b[1] = 1'b0;
    return b;
  endfunction

  function automatic logic [7:0] gamma_hi(input gamma_t g, input int grp);
    logic [7:0] b;
    b = '0;
    for (int k = 0; k < 4; k++) b[7-2*k -: 2] = g[grp*4+k][9:8];
    return b;
  endfunction

  function automatic gamma_t default_gamma();
    gamma_t g;
    g[0]  = 10'd105;  g[1]  = 10'd315;  g[2]  = 10'd381;  g[3]  = 10'd431;
    g[4]  = 10'd490;  g[5]  = 10'd537;  g[6]  = 10'd579;  g[7]  = 10'd686;
    g[8]  = 10'd780;  g[9]  = 10'd837;  g[10] = 10'd880;  g[11] = 10'd1023;
    return g;
  endfunction

endpackage

// File: rtl/lcd_spi_tx.sv
module lcd_spi_tx #(
  parameter int HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] frame,
  output logic        idle,
  output logic        fin,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n
);
  localparam int HW = $clog2(2*HALF + 1);
  localparam logic [HW-1:0] H_END = HW'(HALF - 1);
  localparam logic [HW-1:0] G_END = HW'(2*HALF - 1);

  typedef enum logic [2:0] {T_IDLE, T_LOW, T_HIGH, T_TAIL, T_GAP} tx_state_e;

  tx_state_e   st;
  logic [15:0] sh;
  logic [HW-1:0] hc;
  logic [3:0]  bc;

  assign mosi = sh[15];
  assign idle = (st == T_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= T_IDLE;
      sh   <= '0;
      hc   <= '0;
      bc   <= '0;
      sclk <= 1'b0;
      cs_n <= 1'b1;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (st)
        T_IDLE: if (start) begin
          sh   <= frame;
          cs_n <= 1'b0;
          hc   <= '0;
          bc   <= '0;
          st   <= T_LOW;
        end
        T_LOW: if (hc == H_END) begin
          hc   <= '0;
          sclk <= 1'b1;
          st   <= T_HIGH;
        end else hc <= hc + 1'b1;
        T_HIGH: if (hc == H_END) begin
          hc   <= '0;
          sclk <= 1'b0;
          if (bc == 4'd15) st <= T_TAIL;
          else begin
            sh <= {sh[14:0], 1'b0};
            bc <= bc + 1'b1;
            st <= T_LOW;
          end
        end else hc <= hc + 1'b1;
        T_TAIL: if (hc == H_END) begin
          hc   <= '0;
          cs_n <= 1'b1;
          st   <= T_GAP;
        end else hc <= hc + 1'b1;
        T_GAP: if (hc == G_END) begin
          hc  <= '0;
          fin <= 1'b1;
          st  <= T_IDLE;
        end else hc <= hc + 1'b1;
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_delay_tmr.sv
module lcd_delay_tmr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expire
);
  logic [W-1:0] cnt;
  logic         run;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= len - 1'b1;
      run <= 1'b1;
    end else if (expire) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/lcd_cfg_frames.sv
module lcd_cfg_frames
  import lcd_cfg_pkg::*;
(
  input  frame_kind_e  kind,
  input  logic [4:0]   step,
  input  logic [2:0]   mode,
  input  logic         hmir,
  input  logic         vmir,
  input  gamma_t       gam,
  output logic [15:0]  frame
);
  logic [5:0] addr;
  logic [7:0] data;
  int         s;

  always_comb begin
    s    = int'(step);
    addr = A_MODE;
    data = '0;
    unique case (kind)
      FK_ON: begin
        if (s == 0) begin
          addr = A_MODE;
          data = {4'b0001, 1'b0, mode} | 8'h08;
          data[7:4] = 4'h0;
        end else if (s == 1) begin
          addr = A_PWR;  data = PWR_RUN;
        end else if (s == 2) begin
          addr = A_DRV0; data = DRV_VAL;
        end else if (s == 3) begin
          addr = A_DRV1; data = DRV_VAL;
        end else if (s == 4) begin
          addr = A_FLIP; data = flip_byte(hmir, vmir);
        end else if (s < 8) begin
          addr = A_GHI + 6'(s - 5);
          data = gamma_hi(gam, s - 5);
        end else begin
          addr = A_GLO + 6'(s - 8);
          data = gam[s-8][7:0];
        end
      end
      FK_MIR:  begin addr = A_FLIP; data = flip_byte(hmir, vmir); end
      FK_OFF1: begin addr = A_PWR;  data = PWR_PWM;  end
      FK_OFF2: begin addr = A_PWR;  data = PWR_STBY; end
      default: begin addr = A_PWR;  data = PWR_STBY; end
    endcase
    frame = mk_frame(addr, data);
  end
endmodule

// File: rtl/lcd_cfg_seq.sv
module lcd_cfg_seq
  import lcd_cfg_pkg::*;
#(
  parameter int CLK_KHZ   = 125000,
  parameter int ON_MS     = 160,
  parameter int OFF_MS    = 50,
  parameter int SCLK_HALF = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_on_req,
  input  logic         pwr_off_req,
  input  logic         mirror_req,
  input  logic         cfg_load,
  input  logic [2:0]   cfg_mode,
  input  logic         cfg_hmir,
  input  logic         cfg_vmir,
  input  logic [119:0] cfg_gamma,
  output logic         vdd_en,
  output logic         panel_rst_n,
  output logic         spi_sclk,
  output logic         spi_mosi,
  output logic         spi_cs_n,
  output logic         busy,
  output logic         done
);
  localparam int ON_CYC  = ON_MS * CLK_KHZ;
  localparam int OFF_CYC = OFF_MS * CLK_KHZ;
  localparam int MAX_CYC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam logic [4:0] LAST_STEP = 5'(ON_STEPS - 1);

  seq_state_e  state;
  logic [4:0]  step;
  logic        pend;
  logic [2:0]  mode_q;
  logic        hmir_q, vmir_q;
  gamma_t      gam_q;

  // named internal events
  logic        idle_w, acc_on, acc_off, acc_mir, load_ok, wr_state;
  logic        tx_start, tx_idle, tx_fin, tmr_load, tmr_exp;
  logic [TW-1:0] tmr_len;
  logic [15:0] cur_frame;
  frame_kind_e kind;

  assign idle_w   = (state == S_IDLE);
  assign busy     = !idle_w;
  assign acc_off  = idle_w && pwr_off_req && vdd_en;
  assign acc_on   = idle_w && pwr_on_req && !vdd_en;
  assign acc_mir  = idle_w && mirror_req && vdd_en && !pwr_off_req;
  assign load_ok  = idle_w && cfg_load;
  assign wr_state = (state == S_ON_WR) || (state == S_MIR_WR) ||
                    (state == S_OFF_W1) || (state == S_OFF_W2);
  assign tx_start = wr_state && tx_idle && !pend;
  assign tmr_load = acc_on || ((state == S_OFF_W1) && tx_fin);
  assign tmr_len  = acc_on ? TW'(ON_CYC) : TW'(OFF_CYC);

  always_comb begin
    unique case (state)
      S_MIR_WR: kind = FK_MIR;
      S_OFF_W1: kind = FK_OFF1;
      S_OFF_W2: kind = FK_OFF2;
      default:  kind = FK_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= DEF_MODE;
      hmir_q <= 1'b0;
      vmir_q <= 1'b0;
      gam_q  <= default_gamma();
    end else if (load_ok) begin
      mode_q <= cfg_mode;
      hmir_q <= cfg_hmir;
      vmir_q <= cfg_vmir;
      gam_q  <= gamma_t'(cfg_gamma);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      step        <= '0;
      pend        <= 1'b0;
      vdd_en      <= 1'b0;
      panel_rst_n <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tx_start)    pend <= 1'b1;
      else if (tx_fin) pend <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (acc_off)      state <= S_OFF_W1;
          else if (acc_on) begin
            vdd_en <= 1'b1;
            state  <= S_ON_WAIT;
          end else if (acc_mir) state <= S_MIR_WR;
        end
        S_ON_WAIT: if (tmr_exp) begin
          panel_rst_n <= 1'b1;
          step        <= '0;
          state       <= S_ON_WR;
        end
        S_ON_WR: if (tx_fin) begin
          if (step == LAST_STEP) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else step <= step + 1'b1;
        end
        S_MIR_WR: if (tx_fin) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        S_OFF_W1: if (tx_fin) begin
          panel_rst_n <= 1'b0;
          state       <= S_OFF_WAIT;
        end
        S_OFF_WAIT: if (tmr_exp) state <= S_OFF_W2;
        S_OFF_W2: if (tx_fin) begin
          vdd_en <= 1'b0;
          state  <= S_IDLE;
          done   <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  lcd_cfg_frames u_frames (
    .kind  (kind),
    .step  (step),
    .mode  (mode_q),
    .hmir  (hmir_q),
    .vmir  (vmir_q),
    .gam   (gam_q),
    .frame (cur_frame)
  );

  lcd_delay_tmr #(.W(TW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .len    (tmr_len),
    .expire (tmr_exp)
  );

  lcd_spi_tx #(.HALF(SCLK_HALF)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tx_start),
    .frame (cur_frame),
    .idle  (tx_idle),
    .fin   (tx_fin),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .cs_n  (spi_cs_n)
  );
endmodule

// File: rtl/lcd_cfg_seq_chk.sv
module lcd_cfg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic vdd_en,
  input logic panel_rst_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs_n,
  input logic busy,
  input logic done
);
  logic       cs_q, sclk_q;
  logic [4:0] edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sclk_q   <= 1'b0;
      edge_cnt <= '0;
    end else begin
      cs_q   <= spi_cs_n;
      sclk_q <= spi_sclk;
      if (cs_q && !spi_cs_n) edge_cnt <= '0;
      else if (spi_sclk && !sclk_q && !spi_cs_n) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  // R2
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> !spi_cs_n);
  // R2
  mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi));
  // R2
  sixteen_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (edge_cnt == 5'd16));
  // R3
  reset_release_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panel_rst_n) |-> vdd_en);
  // R9
  no_traffic_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vdd_en |-> spi_cs_n);
  // R8
  supply_drop_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vdd_en) |-> !panel_rst_n);
  // R11
  frame_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
  // R11
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind lcd_cfg_seq lcd_cfg_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vdd_en      (vdd_en),
  .panel_rst_n (panel_rst_n),
  .spi_sclk    (spi_sclk),
  .spi_mosi    (spi_mosi),
  .spi_cs_n    (spi_cs_n),
  .busy        (busy),
  .done        (done)
);

// File: tb/lcd_cfg_seq_bench.sv
module lcd_cfg_seq_bench;
  localparam int CLK_KHZ = 1;
  localparam int ON_MS = 160;
  localparam int OFF_MS = 50;
  localparam int ON_N = ON_MS * CLK_KHZ;
  localparam int OFF_N = OFF_MS * CLK_KHZ;

  // {hmir, vmir, expected register 4 data}
  localparam logic [9:0] MIR_TBL [0:3] = '{10'h017, 10'h216, 10'h115, 10'h314};

  logic clk = 0, rst_n = 0;
  logic pwr_on_req = 0, pwr_off_req = 0, mirror_req = 0, cfg_load = 0;
  logic [2:0] cfg_mode = 3'd7;
  logic cfg_hmir = 0, cfg_vmir = 0;
  logic [119:0] cfg_gamma;
  logic vdd_en, panel_rst_n, spi_sclk, spi_mosi, spi_cs_n, busy, done;

  int checks = 0, fails = 0, cyc = 0;
  int cap_n = 0, done_n = 0, rise_cyc = 0, fall_cyc = 0;
  bit mon_en = 0;
  logic [15:0] sh;
  int bitc;
  logic [15:0] cap [0:63];
  int cap_bits [0:63];
  logic fr_rst [0:63];
  int fr_cyc [0:63];
  int exp_fr [0:19];
  int dg [12] = '{105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023};
  int cg [12] = '{0, 256, 512, 768, 1023, 1, 300, 600, 900, 128, 700, 1000};

  always #4 clk = ~clk;

  lcd_cfg_seq #(.CLK_KHZ(CLK_KHZ), .ON_MS(ON_MS), .OFF_MS(OFF_MS), .SCLK_HALF(1)) u_lcd_cfg_seq (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .mirror_req(mirror_req), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_hmir(cfg_hmir), .cfg_vmir(cfg_vmir), .cfg_gamma(cfg_gamma),
    .vdd_en(vdd_en), .panel_rst_n(panel_rst_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .busy(busy), .done(done));

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mon_en && done) done_n = done_n + 1;
  end
  always @(negedge spi_cs_n) if (mon_en) begin
    sh = 0; bitc = 0;
    if (cap_n < 64) begin fr_rst[cap_n] = panel_rst_n; fr_cyc[cap_n] = cyc; end
  end
  always @(posedge spi_sclk) if (mon_en && !spi_cs_n) begin
    sh = {sh[14:0], spi_mosi}; bitc = bitc + 1;
  end
  always @(posedge spi_cs_n) if (mon_en) begin
    if (cap_n < 64) begin cap[cap_n] = sh; cap_bits[cap_n] = bitc; end
    cap_n = cap_n + 1;
  end
  always @(posedge panel_rst_n) if (mon_en) rise_cyc = cyc;
  always @(negedge panel_rst_n) if (mon_en) fall_cyc = cyc;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic int fr(input int a, input int d);
    return a * 1024 + 256 + d;
  endfunction

  task automatic build_on(input int m, input int h, input int v, input int g[12]);
    exp_fr[0] = fr(2, 8 + m);
    exp_fr[1] = fr(3, 218);
    exp_fr[2] = fr(32, 240);
    exp_fr[3] = fr(33, 240);
    exp_fr[4] = fr(4, 23 - h - 2 * v);
    for (int k = 0; k < 3; k++)
      exp_fr[5+k] = fr(17 + k, (g[4*k]/256)*64 + (g[4*k+1]/256)*16 + (g[4*k+2]/256)*4 + g[4*k+3]/256);
    for (int i = 0; i < 12; i++) exp_fr[8+i] = fr(20 + i, g[i] % 256);
  endtask

  function automatic string step_req(input int i);
    if (i < 4) return "R4";
    if (i == 4) return "R5";
    if (i < 8) return "R6";
    return "R7";
  endfunction

  task automatic set_gamma(input int g[12]);
    for (int i = 0; i < 12; i++) cfg_gamma[10*i +: 10] = 10'(g[i]);
  endtask

  task automatic pulse_on();  pwr_on_req = 1;  @(negedge clk); pwr_on_req = 0;  endtask
  task automatic pulse_off(); pwr_off_req = 1; @(negedge clk); pwr_off_req = 0; endtask
  task automatic pulse_mir(); mirror_req = 1;  @(negedge clk); mirror_req = 0;  endtask
  task automatic pulse_load(); cfg_load = 1;   @(negedge clk); cfg_load = 0;    endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n = n + 1; end
    check(n < 5000, req, n, 0);
    @(negedge clk);
  endtask

  task automatic cmp_on(input string tag);
    check(cap_n == 20, "R4", cap_n, 20);
    for (int i = 0; i < 20; i++) begin
      check(int'(cap[i]) == exp_fr[i], (i == 0) ? tag : step_req(i), int'(cap[i]), exp_fr[i]);
      check(cap_bits[i] == 16 && fr_rst[i] == 1'b1, "R2", cap_bits[i], 16);
    end
  endtask

  initial begin
    int t0;
    set_gamma(dg);
    repeat (4) @(negedge clk);
    rst_n = 1;
    mon_en = 1;
    @(negedge clk);
    // R1 reset state
    check(vdd_en == 0 && panel_rst_n == 0, "R1", {vdd_en, panel_rst_n}, 0);
    check(spi_cs_n == 1 && spi_sclk == 0, "R1", {spi_cs_n, spi_sclk}, 2);
    check(busy == 0 && done == 0, "R1", {busy, done}, 0);

    // R9 mirror and power-off while unpowered are ignored
    pulse_mir();
    pulse_off();
    repeat (60) @(negedge clk);
    check(cap_n == 0 && busy == 0 && done_n == 0 && vdd_en == 0, "R9", cap_n, 0);

    // R3/R4..R7 power-up with default settings (R1 defaults)
    t0 = cyc;
    pulse_on();
    check(busy == 1 && vdd_en == 1, "R11", {busy, vdd_en}, 3);
    repeat (ON_N - 10) @(negedge clk);
    check(panel_rst_n == 0 && cap_n == 0, "R3", cap_n, 0);
    wait_done("R11");
    check(rise_cyc - t0 >= ON_N && rise_cyc - t0 < ON_N + 4, "R3", rise_cyc - t0, ON_N);
    build_on(7, 0, 0, dg);
    cmp_on("R1");
    check(done_n == 1 && busy == 0, "R11", done_n, 1);

    // R9 redundant power-on
    cap_n = 0; done_n = 0;
    pulse_on();
    repeat (60) @(negedge clk);
    check(cap_n == 0 && done_n == 0 && vdd_en == 1 && panel_rst_n == 1, "R9", cap_n, 0);

    // R10/R5 mirror table
    for (int i = 0; i < 4; i++) begin
      cfg_hmir = MIR_TBL[i][9]; cfg_vmir = MIR_TBL[i][8];
      pulse_load();
      cap_n = 0;
      pulse_mir();
      wait_done("R10");
      check(cap_n == 1, "R10", cap_n, 1);
      check(int'(cap[0]) == fr(4, int'(MIR_TBL[i][7:0])), "R5", int'(cap[0]), fr(4, int'(MIR_TBL[i][7:0])));
    end

    // R11 load and power-off during a running script are ignored
    cap_n = 0;
    pulse_mir();
    cfg_hmir = 0; cfg_vmir = 0;
    pulse_load();
    pulse_off();
    wait_done("R11");
    check(cap_n == 1 && vdd_en == 1, "R11", cap_n, 1);
    cap_n = 0;
    pulse_mir();
    wait_done("R11");
    check(int'(cap[0]) == fr(4, 8'h14), "R11", int'(cap[0]), fr(4, 8'h14));

    // R13 load new settings; R12/R8 power-off with simultaneous mirror
    cfg_mode = 3'd3; cfg_hmir = 0; cfg_vmir = 1;
    set_gamma(cg);
    pulse_load();
    cap_n = 0;
    pwr_off_req = 1; mirror_req = 1;
    @(negedge clk);
    pwr_off_req = 0; mirror_req = 0;
    wait_done("R8");
    check(cap_n == 2, "R12", cap_n, 2);
    check(int'(cap[0]) == fr(3, 8'hD8) && fr_rst[0] == 1, "R8", int'(cap[0]), fr(3, 8'hD8));
    check(int'(cap[1]) == fr(3, 8'hD0) && fr_rst[1] == 0, "R8", int'(cap[1]), fr(3, 8'hD0));
    check(fr_cyc[1] - fall_cyc >= OFF_N && fr_cyc[1] - fall_cyc < OFF_N + 8, "R8", fr_cyc[1] - fall_cyc, OFF_N);
    check(vdd_en == 0 && panel_rst_n == 0, "R8", {vdd_en, panel_rst_n}, 0);

    // R13 power-up uses loaded settings
    cap_n = 0;
    pulse_on();
    wait_done("R13");
    build_on(3, 0, 1, cg);
    cmp_on("R13");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule